// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives software a narrow window onto a 32-bit-address peripheral bus. Software sees four 64-bit registers on a configuration port. It loads a 32-bit data value, then writes a command word that names the target address, the byte count and the direction. The bridge runs exactly one transaction on the downstream bus and posts the outcome into a status register. Reading the status register returns the outcome and empties it.

The downstream side is a request/response master. A request is offered with a valid/ready handshake. The reply comes back later as a one-cycle strobe with read data and an error bit. Only one transaction is in flight at a time. Further commands are ignored until the reply arrives, and status reads show zero while the transaction is outstanding. Bytes travel most significant first: byte 0 of a transfer sits in bits 31:24 of every 32-bit bus data field.

Top module: `ind_reg_bridge`

## Requirements
- R1: Address bits 4:3 select the register (0 command, 1 reset, 2 status, 3 data), and all other address bits are ignored. Every read returns its data with `cfg_rvalid` high in the cycle after the access. The command and reset registers always read as zero. After reset, `cfg_rvalid` and `bus_req_valid` are low.
- R2: A data-register write keeps bits 63:32 of the written word. A data-register read returns that value in bits 63:32 with zeros in bits 31:0. Reset value is zero.
- R3: A command write with byte count of 8 or less starts a request that is visible in the cycle after the write. Bit 48 set means read; bits 59:56 give the byte count; bits 31:0 give the target address. The request holds its fields until `bus_req_ready` is seen.
- R4: A command whose byte count exceeds 8 starts no request and leaves the status register unchanged.
- R5: A write request carries the stored data value on `bus_req_wdata`. When its response arrives, status becomes 0x800 (done flag, bit 11) whatever the error bit says.
- R6: A read response without error sets status to the done flag (bit 11) with `bus_rsp_rdata` placed in bits 57:26.
- R7: A read response with error sets status to the done flag with bits 57:26 all ones, which is 0x03FFFFFFFC000800.
- R8: A status read returns the current status and clears the register. A second read then returns zero.
- R9: Writes to the status and reset registers change no register.
- R10: From the cycle a request starts until its response arrives, command writes are ignored, and status reads return zero. Each command produces exactly one handshake.
- R11: When a status read falls in the same cycle as a response, the read returns zero and the newly posted result is kept for the next read.
- R12: A data-register write while a request is pending does not alter the `bus_req_wdata` of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Configuration access strobe, one cycle per access |
| cfg_we | input | 1 | 1 = write access, 0 = read access |
| cfg_addr | input | CFG_AW | Byte address; bits 4:3 select the register |
| cfg_wdata | input | 64 | Write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read access |
| cfg_rdata | output | 64 | Read data |
| bus_req_valid | output | 1 | Downstream request valid |
| bus_req_ready | input | 1 | Downstream request accepted |
| bus_req_write | output | 1 | 1 = write transaction |
| bus_req_addr | output | 32 | Target address |
| bus_req_size | output | 4 | Byte count |
| bus_req_wdata | output | 32 | Write bytes, byte 0 in bits 31:24 |
| bus_rsp_valid | input | 1 | Response strobe |
| bus_rsp_err | input | 1 | Response error |
| bus_rsp_rdata | input | 32 | Read bytes, byte 0 in bits 31:24 |

## Verification
Two collisions matter here. First, a response can post a result in the same cycle that a status read is clearing the register. The bench withholds the response by hand and puts the status read exactly on the response cycle. It then expects zero from that read and the full result from the next read. Second, a data-register write or a new command can land while a request is held off by a low ready. The bench checks that the pending request's address and data stay frozen.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int WORD_W     = 64;
  localparam int TADDR_W    = 32;
  localparam int BDATA_W    = 32;
  localparam int SZ_W       = 4;
  localparam int CMD_RD_BIT = 48;
  localparam int CMD_SZ_LO  = 56;
  localparam int DONE_BIT   = 11;
  localparam int RDATA_LO   = 26;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RSTR = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    BM_IDLE = 2'd0,
    BM_REQ  = 2'd1,
    BM_WAIT = 2'd2
  } bm_state_e;

  typedef struct packed {
    logic                rd;
    logic [SZ_W-1:0]     size;
    logic [TADDR_W-1:0]  addr;
  } cmd_t;
endpackage

// File: rtl/ibr_cmd_decode.sv
module ibr_cmd_decode
  import ibr_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic [WORD_W-1:0] word_i,
  output cmd_t              cmd_o,
  output logic              oversize_o
);
  localparam logic [SZ_W:0] LIMIT = (SZ_W+1)'(MAX_BYTES);

  logic unused_fields;
  assign unused_fields = ^{word_i[WORD_W-1:CMD_SZ_LO+SZ_W],
                           word_i[CMD_SZ_LO-1:CMD_RD_BIT+1],
                           word_i[CMD_RD_BIT-1:TADDR_W]};

  always_comb begin
    cmd_o.rd   = word_i[CMD_RD_BIT];
    cmd_o.size = word_i[CMD_SZ_LO +: SZ_W];
    cmd_o.addr = word_i[TADDR_W-1:0];
    oversize_o = {1'b0, cmd_o.size} > LIMIT;
  end
endmodule

// File: rtl/ibr_bus_master.sv
module ibr_bus_master
  import ibr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr_i,
  input  cmd_t               cmd_i,
  input  logic               oversize_i,
  input  logic [BDATA_W-1:0] wdata_i,
  output logic               launch_o,
  output logic               busy_o,
  output logic               bus_req_valid_o,
  input  logic               bus_req_ready_i,
  output logic               bus_req_write_o,
  output logic [TADDR_W-1:0] bus_req_addr_o,
  output logic [SZ_W-1:0]    bus_req_size_o,
  output logic [BDATA_W-1:0] bus_req_wdata_o,
  input  logic               bus_rsp_valid_i,
  input  logic               bus_rsp_err_i,
  input  logic [BDATA_W-1:0] bus_rsp_rdata_i,
  output logic               done_stb_o,
  output logic               done_rd_o,
  output logic               done_err_o,
  output logic [BDATA_W-1:0] done_rdata_o
);
  bm_state_e          state_q, state_d;
  logic               write_q;
  logic [TADDR_W-1:0] addr_q;
  logic [SZ_W-1:0]    size_q;
  logic [BDATA_W-1:0] wdata_q;
  logic               launch;

  assign launch = ctrl_wr_i && !oversize_i && (state_q == BM_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      BM_IDLE: if (launch)          state_d = BM_REQ;
      BM_REQ:  if (bus_req_ready_i) state_d = BM_WAIT;
      BM_WAIT: if (bus_rsp_valid_i) state_d = BM_IDLE;
      default:                      state_d = BM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BM_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
    end else if (launch) begin
      write_q <= !cmd_i.rd;
      addr_q  <= cmd_i.addr;
      size_q  <= cmd_i.size;
      wdata_q <= wdata_i;
    end
  end

  assign launch_o        = launch;
  assign busy_o          = (state_q != BM_IDLE);
  assign bus_req_valid_o = (state_q == BM_REQ);
  assign bus_req_write_o = write_q;
  assign bus_req_addr_o  = addr_q;
  assign bus_req_size_o  = size_q;
  assign bus_req_wdata_o = wdata_q;
  assign done_stb_o      = (state_q == BM_WAIT) && bus_rsp_valid_i;
  assign done_rd_o       = !write_q;
  assign done_err_o      = bus_rsp_err_i;
  assign done_rdata_o    = bus_rsp_rdata_i;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid_o && !bus_req_ready_i |=> bus_req_valid_o && $stable(bus_req_addr_o)
      && $stable(bus_req_size_o) && $stable(bus_req_wdata_o)); // R3
  AST_SINGLE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid_o && bus_req_ready_i |=> !bus_req_valid_o); // R10
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && ctrl_wr_i |=> $stable(bus_req_addr_o) && $stable(bus_req_wdata_o)); // R12
endmodule

// File: rtl/ibr_regfile.sv
module ibr_regfile
  import ibr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_req_i,
  input  logic               cfg_we_i,
  input  reg_sel_e           sel_i,
  input  logic [WORD_W-1:0]  cfg_wdata_i,
  input  logic               launch_i,
  input  logic               done_stb_i,
  input  logic               done_rd_i,
  input  logic               done_err_i,
  input  logic [BDATA_W-1:0] done_rdata_i,
  output logic [BDATA_W-1:0] data_o,
  output logic               cfg_rvalid_o,
  output logic [WORD_W-1:0]  cfg_rdata_o
);
  logic [BDATA_W-1:0] data_q;
  logic [WORD_W-1:0]  stat_q, stat_d, result;
  logic [WORD_W-1:0]  rdata_d;
  logic               rd_acc, data_wr, stat_rd;

  logic unused_low;
  assign unused_low = ^cfg_wdata_i[WORD_W-BDATA_W-1:0];

  assign rd_acc  = cfg_req_i && !cfg_we_i;
  assign data_wr = cfg_req_i && cfg_we_i && (sel_i == SEL_DATA);
  assign stat_rd = rd_acc && (sel_i == SEL_STAT);

  always_comb begin
    result           = '0;
    result[DONE_BIT] = 1'b1;
    if (done_rd_i)
      result[RDATA_LO +: BDATA_W] = done_err_i ? {BDATA_W{1'b1}} : done_rdata_i;
  end

  always_comb begin
    stat_d = stat_q;
    if (done_stb_i)    stat_d = result;
    else if (launch_i) stat_d = '0;
    else if (stat_rd)  stat_d = '0;
  end

  always_comb begin
    rdata_d = '0;
    case (sel_i)
      SEL_STAT: rdata_d = stat_q;
      SEL_DATA: rdata_d = {data_q, {(WORD_W-BDATA_W){1'b0}}};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_wr) data_q <= cfg_wdata_i[WORD_W-1 -: BDATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rvalid_o <= 1'b0;
      cfg_rdata_o  <= '0;
    end else begin
      cfg_rvalid_o <= rd_acc;
      if (rd_acc) cfg_rdata_o <= rdata_d;
    end
  end

  assign data_o = data_q;

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> cfg_rvalid_o); // R1
  AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !done_stb_i |=> stat_q == '0); // R8
  AST_DONE_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb_i |=> stat_q[DONE_BIT]); // R5
  AST_DATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(data_q)); // R2
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_stb_i && !launch_i && !stat_rd |=> $stable(stat_q)); // R9
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ibr_pkg::*;
#(
  parameter int CFG_AW    = 8,
  parameter int SEL_LSB   = 3,
  parameter int MAX_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [63:0]       cfg_wdata,
  output logic              cfg_rvalid,
  output logic [63:0]       cfg_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [31:0]       bus_req_addr,
  output logic [3:0]        bus_req_size,
  output logic [31:0]       bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_err,
  input  logic [31:0]       bus_rsp_rdata
);
  logic               rst_meta, rst_sync;
  reg_sel_e           sel;
  cmd_t               cmd;
  logic               oversize, ctrl_wr, launch, busy;
  logic               done_stb, done_rd, done_err;
  logic [BDATA_W-1:0] done_rdata, data_val;

  logic unused_addr;
  assign unused_addr = ^cfg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign sel     = reg_sel_e'(cfg_addr[SEL_LSB+1:SEL_LSB]);
  assign ctrl_wr = cfg_req && cfg_we && (sel == SEL_CTRL);

  ibr_cmd_decode #(.MAX_BYTES(MAX_BYTES)) u_dec (
    .word_i     (cfg_wdata),
    .cmd_o      (cmd),
    .oversize_o (oversize)
  );

  ibr_bus_master u_bm (
    .clk             (clk),
    .rst_n           (rst_sync),
    .ctrl_wr_i       (ctrl_wr),
    .cmd_i           (cmd),
    .oversize_i      (oversize),
    .wdata_i         (data_val),
    .launch_o        (launch),
    .busy_o          (busy),
    .bus_req_valid_o (bus_req_valid),
    .bus_req_ready_i (bus_req_ready),
    .bus_req_write_o (bus_req_write),
    .bus_req_addr_o  (bus_req_addr),
    .bus_req_size_o  (bus_req_size),
    .bus_req_wdata_o (bus_req_wdata),
    .bus_rsp_valid_i (bus_rsp_valid),
    .bus_rsp_err_i   (bus_rsp_err),
    .bus_rsp_rdata_i (bus_rsp_rdata),
    .done_stb_o      (done_stb),
    .done_rd_o       (done_rd),
    .done_err_o      (done_err),
    .done_rdata_o    (done_rdata)
  );

  ibr_regfile u_rf (
    .clk          (clk),
    .rst_n        (rst_sync),
    .cfg_req_i    (cfg_req),
    .cfg_we_i     (cfg_we),
    .sel_i        (sel),
    .cfg_wdata_i  (cfg_wdata),
    .launch_i     (launch),
    .done_stb_i   (done_stb),
    .done_rd_i    (done_rd),
    .done_err_i   (done_err),
    .done_rdata_i (done_rdata),
    .data_o       (data_val),
    .cfg_rvalid_o (cfg_rvalid),
    .cfg_rdata_o  (cfg_rdata)
  );

  AST_OVERSIZE_DROP: assert property (@(posedge clk) disable iff (!rst_sync)
    ctrl_wr && oversize && !busy |=> !bus_req_valid); // R4
endmodule

// File: tb/sim_ind_reg_bridge.sv
module sim_ind_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_req = 1'b0, cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        cfg_rvalid;
  logic [63:0] cfg_rdata;
  logic        bus_req_valid, bus_req_write;
  logic        bus_req_ready = 1'b0;
  logic [31:0] bus_req_addr, bus_req_wdata;
  logic [3:0]  bus_req_size;
  logic        bus_rsp_valid = 1'b0, bus_rsp_err = 1'b0;
  logic [31:0] bus_rsp_rdata = '0;

  localparam logic [7:0] A_CTRL = 8'h00, A_RST = 8'h08, A_STAT = 8'h10, A_DATA = 8'h18;
  localparam logic [63:0] DONE = 64'h800;

  int n_chk = 0, n_err = 0, cyc = 0;
  string cur_req = "R1";
  bit auto_rsp = 1'b1, auto_err = 1'b0, mdl_on = 1'b0;
  int rdy_lat = 0, rsp_lat = 0;

  int          m_state = 0;
  logic [63:0] m_stat = '0, e_rdata = '0;
  logic [31:0] m_data = '0, m_addr = '0, m_wdata = '0;
  logic [3:0]  m_size = '0;
  logic        m_wr = 1'b0, e_rvalid = 1'b0;

  always #5 clk = ~clk;

  ind_reg_bridge u0 (.*);

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_cmd(input bit rd, input logic [3:0] sz, input logic [31:0] a);
    return ({63'd0, rd} << 48) | ({60'd0, sz} << 56) | {32'd0, a};
  endfunction

  function automatic logic [63:0] rd_stat(input logic [31:0] d);
    return DONE | ({32'd0, d} << 26);
  endfunction

  task automatic cfg_wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = 1'b0; cfg_addr = a;
    @(negedge clk);
    cfg_req = 1'b0;
    d = cfg_rdata;
    chk("R1 rvalid", {63'd0, cfg_rvalid}, 64'd1);
  endtask

  // behavioural reference model, advanced at every rising edge
  always @(posedge clk) begin
    int o_state;
    logic [63:0] o_stat;
    if (!rst_n) begin
      m_state = 0; m_stat = '0; m_data = '0; e_rvalid = 1'b0;
    end else begin
      o_state = m_state; o_stat = m_stat;
      e_rvalid = cfg_req && !cfg_we;
      if (e_rvalid) begin
        case (cfg_addr[4:3])
          2'd2:    e_rdata = o_stat;
          2'd3:    e_rdata = {m_data, 32'd0};
          default: e_rdata = '0;
        endcase
        if (cfg_addr[4:3] == 2'd2) m_stat = '0;
      end
      if (o_state == 2 && bus_rsp_valid) begin
        m_state = 0;
        if (m_wr)             m_stat = DONE;
        else if (bus_rsp_err) m_stat = rd_stat(32'hFFFF_FFFF);
        else                  m_stat = rd_stat(bus_rsp_rdata);
      end
      if (o_state == 1 && bus_req_ready) m_state = 2;
      if (cfg_req && cfg_we && cfg_addr[4:3] == 2'd0 && o_state == 0
          && cfg_wdata[59:56] <= 4'd8) begin
        m_state = 1; m_wr = !cfg_wdata[48]; m_size = cfg_wdata[59:56];
        m_addr = cfg_wdata[31:0]; m_wdata = m_data; m_stat = '0;
      end
      if (cfg_req && cfg_we && cfg_addr[4:3] == 2'd3) m_data = cfg_wdata[63:32];
    end
  end

  always @(negedge clk) begin
    if (mdl_on) begin
      chk({cur_req, " req_valid"}, {63'd0, bus_req_valid}, {63'd0, m_state == 1});
      if (m_state == 1) begin
        chk({cur_req, " req_addr"}, {32'd0, bus_req_addr}, {32'd0, m_addr});
        chk({cur_req, " req_size"}, {60'd0, bus_req_size}, {60'd0, m_size});
        chk({cur_req, " req_write"}, {63'd0, bus_req_write}, {63'd0, m_wr});
        if (m_wr) chk({cur_req, " req_wdata"}, {32'd0, bus_req_wdata}, {32'd0, m_wdata});
      end
      chk({cur_req, " rvalid"}, {63'd0, cfg_rvalid}, {63'd0, e_rvalid});
      if (e_rvalid) chk({cur_req, " rdata"}, cfg_rdata, e_rdata);
    end
  end

  // automatic downstream responder
  initial begin
    logic [31:0] a;
    forever begin
      @(negedge clk);
      if (auto_rsp && bus_req_valid && !bus_req_ready) begin
        a = bus_req_addr;
        repeat (rdy_lat) @(negedge clk);
        bus_req_ready = 1'b1;
        @(negedge clk);
        bus_req_ready = 1'b0;
        repeat (rsp_lat) @(negedge clk);
        bus_rsp_valid = 1'b1; bus_rsp_err = auto_err; bus_rsp_rdata = a ^ 32'h5A5A_F00F;
        @(negedge clk);
        bus_rsp_valid = 1'b0; bus_rsp_err = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, prev;
    repeat (3) @(negedge clk);
    chk("R1 reset rvalid", {63'd0, cfg_rvalid}, 64'd0);
    chk("R1 reset req_valid", {63'd0, bus_req_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mdl_on = 1'b1;

    cur_req = "R2";
    cfg_rd(A_DATA, d);           chk("R2 data reset", d, 64'd0);
    cfg_rd(A_STAT, d);           chk("R8 stat reset", d, 64'd0);
    cfg_wr(A_DATA, 64'h1234_5678_9ABC_DEF0);
    cfg_rd(A_DATA, d);           chk("R2 data upper", d, 64'h1234_5678_0000_0000);

    cur_req = "R1";
    cfg_rd(A_CTRL, d);           chk("R1 ctrl reads zero", d, 64'd0);
    cfg_rd(A_RST, d);            chk("R1 reset reg reads zero", d, 64'd0);
    cfg_rd(8'hF8, d);            chk("R1 alias to data", d, 64'h1234_5678_0000_0000);

    cur_req = "R3";
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a;
      logic [3:0]  sz;
      a  = 32'hD001_0000 + 32'(i * 32'h0101_0040);
      sz = (i == 0) ? 4'd0 : (i == 1) ? 4'd8 : 4'(i);
      rdy_lat = i; rsp_lat = 3 - i;
      cfg_wr(A_CTRL, mk_cmd(1'b1, sz, a));
      chk("R3 valid after cmd", {63'd0, bus_req_valid}, 64'd1);
      chk("R3 addr field", {32'd0, bus_req_addr}, {32'd0, a});
      chk("R3 size field", {60'd0, bus_req_size}, {60'd0, sz});
      chk("R3 read dir", {63'd0, bus_req_write}, 64'd0);
      repeat (10) @(negedge clk);
      cfg_rd(A_STAT, d);         chk("R6 read result", d, rd_stat(a ^ 32'h5A5A_F00F));
    end

    cur_req = "R9";
    rdy_lat = 0; rsp_lat = 1;
    cfg_wr(A_CTRL, mk_cmd(1'b1, 4'd4, 32'h0000_1000));
    repeat (8) @(negedge clk);
    cfg_wr(A_STAT, 64'd0);
    cfg_wr(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
    cfg_rd(A_DATA, d);           chk("R9 reset write leaves data", d, 64'h1234_5678_0000_0000);
    cfg_rd(A_STAT, d);           chk("R9 stat write no effect", d, rd_stat(32'h0000_1000 ^ 32'h5A5A_F00F));
    cfg_rd(A_STAT, d);           chk("R8 stat cleared", d, 64'd0);

    cur_req = "R7";
    auto_err = 1'b1;
    cfg_wr(A_CTRL, mk_cmd(1'b1, 4'd2, 32'hE000_0044));
    repeat (8) @(negedge clk);
    cfg_rd(A_STAT, d);           chk("R7 failed read", d, 64'h03FF_FFFF_FC00_0800);

    cur_req = "R5";
    cfg_wr(A_DATA, {32'hCAFE_F00D, 32'h0});
    cfg_wr(A_CTRL, mk_cmd(1'b0, 4'd4, 32'hD001_0060));
    chk("R5 write dir", {63'd0, bus_req_write}, 64'd1);
    chk("R5 write bytes", {32'd0, bus_req_wdata}, 64'hCAFE_F00D);
    repeat (8) @(negedge clk);
    cfg_rd(A_STAT, d);           chk("R5 write status with err", d, DONE);
    auto_err = 1'b0;

    cur_req = "R4";
    cfg_wr(A_CTRL, mk_cmd(1'b1, 4'd1, 32'h0000_0020));
    repeat (8) @(negedge clk);
    prev = rd_stat(32'h0000_0020 ^ 32'h5A5A_F00F);
    cfg_wr(A_CTRL, mk_cmd(1'b1, 4'd9, 32'h0000_0030));
    chk("R4 no request size 9", {63'd0, bus_req_valid}, 64'd0);
    cfg_wr(A_CTRL, mk_cmd(1'b0, 4'd15, 32'h0000_0034));
    repeat (3) @(negedge clk);
    chk("R4 no request size 15", {63'd0, bus_req_valid}, 64'd0);
    cfg_rd(A_STAT, d);           chk("R4 status unchanged", d, prev);

    cur_req = "R10";
    auto_rsp = 1'b0;
    cfg_wr(A_DATA, {32'h1122_3344, 32'h0});
    cfg_wr(A_CTRL, mk_cmd(1'b0, 4'd4, 32'h0000_0200));
    cfg_wr(A_CTRL, mk_cmd(1'b1, 4'd2, 32'h0000_0300));
    chk("R10 second cmd ignored", {32'd0, bus_req_addr}, 64'h200);
    cfg_rd(A_STAT, d);           chk("R10 status zero while busy", d, 64'd0);
    cur_req = "R12";
    cfg_wr(A_DATA, {32'h5566_7788, 32'h0});
    chk("R12 wdata frozen", {32'd0, bus_req_wdata}, 64'h1122_3344);
    @(negedge clk); bus_req_ready = 1'b1;
    @(negedge clk); bus_req_ready = 1'b0;
    cfg_wr(A_CTRL, mk_cmd(1'b1, 4'd4, 32'h0000_0400));
    chk("R10 cmd during wait ignored", {63'd0, bus_req_valid}, 64'd0);
    @(negedge clk); bus_rsp_valid = 1'b1; bus_rsp_err = 1'b1;
    @(negedge clk); bus_rsp_valid = 1'b0; bus_rsp_err = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 one handshake only", {63'd0, bus_req_valid}, 64'd0);
    cfg_rd(A_STAT, d);           chk("R5 manual write status", d, DONE);

    cur_req = "R11";
    cfg_wr(A_CTRL, mk_cmd(1'b1, 4'd4, 32'h0000_0500));
    @(negedge clk); bus_req_ready = 1'b1;
    @(negedge clk); bus_req_ready = 1'b0;
    bus_rsp_valid = 1'b1; bus_rsp_rdata = 32'hDEAD_BEEF;
    cfg_req = 1'b1; cfg_we = 1'b0; cfg_addr = A_STAT;
    @(negedge clk);
    bus_rsp_valid = 1'b0; cfg_req = 1'b0;
    chk("R11 colliding read zero", cfg_rdata, 64'd0);
    cfg_rd(A_STAT, d);           chk("R11 result kept", d, rd_stat(32'hDEAD_BEEF));
    auto_rsp = 1'b1;

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule